// File: doc/BRIEF.md
# Circular-Buffer Post-Modify Address Unit

This unit sits in the address stage of a 16-bit load/store pipeline. For each memory access it gets the base register value and index, the access width (one or two 16-bit words) and an addressing mode. From these it computes the address used for the access and the updated base register value. A circular-buffer mode lets a pointer walk a bounded region and fall back to its start instead of running past the end. The mode is enabled by a status bit, and the region is set by two bound values.

The address and the updated base are combinational. The unit also judges whether the addressing form is legal. It decides whether the updated base may be written back to the register file, and presents that write one clock later on a registered port that lines up with the register file's write port.

Mode encoding on `mode`: 2'b00 post-increment, 2'b01 post-decrement, 2'b10 pre-decrement through the stack pointer, 2'b11 reserved. `is_store` is 1 for a store and 0 for a load. `two_word` is 1 for a two-word access.

Top module: `amg_modulo_agu`

## Requirements
- R1: In post-increment mode (2'b00) without a wrap, `eff_addr` equals `base_val` and `new_base` equals `base_val` plus 2 (word) or plus 4 (two-word). The sum wraps modulo 2^16.
- R2: With `modulo_en` high, post-increment compares `base_val` with `mod_end` after clearing bit 0 (word) or bits 1:0 (two-word). On a match, `new_base` is `mod_start`. An odd end bound therefore wraps at the even word below it.
- R3: In post-decrement mode (2'b01), `eff_addr` equals `base_val` and `new_base` is `base_val` minus 2 or minus 4. With `modulo_en` high, the same masked end-bound compare selects `mod_start` instead.
- R4: With `modulo_en` low, the bounds have no effect, and the base moves past either bound by the plain step.
- R5: Pre-decrement mode (2'b10) with base index 15 uses `base_val` minus the step both as `eff_addr` and as `new_base`. The circular-buffer compare never applies in this mode.
- R6: `illegal` is high for a request with any of the following: mode 2'b11; pre-decrement with a base index other than 15; a post-decrement store with base index 15. Such a request produces no writeback.
- R7: A load does not write back its base when the base index equals `dest_idx`. A two-word load also does not write back when the base index equals `dest_idx`+1 (4-bit wrap). Stores and single-word loads with base index `dest_idx`+1 do write back.
- R8: A legal, unsuppressed request raises `wb_en` on the following clock, with `wb_idx` holding the base index and `wb_data` holding that request's `new_base`. Reset clears `wb_en`.
- R9: When `req_valid` is low, `wb_en` is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| mode | input | 2 | Addressing mode code |
| is_store | input | 1 | 1 = store, 0 = load |
| two_word | input | 1 | 1 = two-word access |
| base_idx | input | 4 | Base register index |
| dest_idx | input | 4 | Load destination register index |
| base_val | input | 16 | Base register value |
| mod_start | input | 16 | Circular buffer start bound |
| mod_end | input | 16 | Circular buffer end bound |
| modulo_en | input | 1 | Circular-buffer mode enable status bit |
| eff_addr | output | 16 | Address for the memory access |
| new_base | output | 16 | Updated base value |
| illegal | output | 1 | Addressing form is illegal |
| wb_en | output | 1 | Registered base writeback enable |
| wb_idx | output | 4 | Registered writeback register index |
| wb_data | output | 16 | Registered writeback value |

## Verification
The assertions assume that all inputs are driven with known values on every clock edge, including when `req_valid` is low, because they sample the mode and index fields on each edge. They also assume that a request is held for a whole cycle.

The bench changes inputs only on falling edges and keeps every field at a defined value between requests. It feeds each computed `new_base` back as the next `base_val`, which mirrors how the register file returns the written value.

// File: rtl/amg_pkg.sv
package amg_pkg;
  typedef enum logic [1:0] {
    AMG_POST_INC = 2'b00,
    AMG_POST_DEC = 2'b01,
    AMG_PRE_DEC  = 2'b10,
    AMG_RSVD     = 2'b11
  } amg_mode_e;
endpackage

// File: rtl/amg_step_unit.sv
module amg_step_unit
  import amg_pkg::*;
#(
  parameter int AW = 16
) (
  input  amg_mode_e         mode_i,
  input  logic              two_word_i,
  input  logic              modulo_en_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     start_i,
  input  logic [AW-1:0]     end_i,
  output logic [AW-1:0]     eff_addr_o,
  output logic [AW-1:0]     next_base_o,
  output logic              wrap_hit_o
);
  // Step size in bytes: one word moves 2, two words move 4.
  function automatic logic [AW-1:0] step_amount(input logic two_w);
    return two_w ? AW'(4) : AW'(2);
  endfunction

  // End bound with the low bits covered by the step cleared.
  function automatic logic [AW-1:0] masked_end(input logic [AW-1:0] e,
                                               input logic two_w);
    return two_w ? {e[AW-1:2], 2'b00} : {e[AW-1:1], 1'b0};
  endfunction

  logic [AW-1:0] step_w;
  logic [AW-1:0] inc_w;
  logic [AW-1:0] dec_w;
  logic          post_mode_w;

  assign step_w      = step_amount(two_word_i);
  assign inc_w       = base_i + step_w;
  assign dec_w       = base_i - step_w;
  assign post_mode_w = (mode_i == AMG_POST_INC) || (mode_i == AMG_POST_DEC);
  assign wrap_hit_o  = modulo_en_i && post_mode_w &&
                       (base_i == masked_end(end_i, two_word_i));

  always_comb begin
    eff_addr_o  = base_i;
    next_base_o = base_i;
    unique case (mode_i)
      AMG_POST_INC: next_base_o = wrap_hit_o ? start_i : inc_w;
      AMG_POST_DEC: next_base_o = wrap_hit_o ? start_i : dec_w;
      AMG_PRE_DEC: begin
        eff_addr_o  = dec_w;
        next_base_o = dec_w;
      end
      default: next_base_o = base_i;
    endcase
  end
endmodule

// File: rtl/amg_access_check.sv
module amg_access_check
  import amg_pkg::*;
#(
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input  logic          valid_i,
  input  amg_mode_e     mode_i,
  input  logic          is_store_i,
  input  logic          two_word_i,
  input  logic [RW-1:0] base_idx_i,
  input  logic [RW-1:0] dest_idx_i,
  output logic          illegal_o,
  output logic          dest_clash_o,
  output logic          wb_allow_o
);
  localparam logic [RW-1:0] SP = RW'(SP_IDX);

  logic [RW-1:0] dest_next_w;
  logic          base_is_sp_w;
  logic          bad_form_w;

  assign dest_next_w  = dest_idx_i + RW'(1);
  assign base_is_sp_w = (base_idx_i == SP);

  always_comb begin
    unique case (mode_i)
      AMG_PRE_DEC:  bad_form_w = !base_is_sp_w;
      AMG_POST_DEC: bad_form_w = is_store_i && base_is_sp_w;
      AMG_RSVD:     bad_form_w = 1'b1;
      default:      bad_form_w = 1'b0;
    endcase
  end

  assign illegal_o    = valid_i && bad_form_w;
  assign dest_clash_o = !is_store_i &&
                        ((base_idx_i == dest_idx_i) ||
                         (two_word_i && (base_idx_i == dest_next_w)));
  assign wb_allow_o   = valid_i && !bad_form_w && !dest_clash_o;
endmodule

// File: rtl/amg_modulo_agu.sv
module amg_modulo_agu
  import amg_pkg::*;
#(
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    mode,
  input  logic          is_store,
  input  logic          two_word,
  input  logic [RW-1:0] base_idx,
  input  logic [RW-1:0] dest_idx,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] mod_start,
  input  logic [AW-1:0] mod_end,
  input  logic          modulo_en,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_base,
  output logic          illegal,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  amg_mode_e mode_w;
  logic      wrap_hit;
  logic      dest_clash;
  logic      wb_allow;

  assign mode_w = amg_mode_e'(mode);

  amg_step_unit #(.AW(AW)) u_step (
    .mode_i      (mode_w),
    .two_word_i  (two_word),
    .modulo_en_i (modulo_en),
    .base_i      (base_val),
    .start_i     (mod_start),
    .end_i       (mod_end),
    .eff_addr_o  (eff_addr),
    .next_base_o (new_base),
    .wrap_hit_o  (wrap_hit)
  );

  amg_access_check #(.RW(RW), .SP_IDX(SP_IDX)) u_check (
    .valid_i      (req_valid),
    .mode_i       (mode_w),
    .is_store_i   (is_store),
    .two_word_i   (two_word),
    .base_idx_i   (base_idx),
    .dest_idx_i   (dest_idx),
    .illegal_o    (illegal),
    .dest_clash_o (dest_clash),
    .wb_allow_o   (wb_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= wb_allow;
      wb_idx  <= base_idx;
      wb_data <= new_base;
    end
  end
endmodule

// File: rtl/amg_modulo_agu_chk.sv
module amg_modulo_agu_chk #(
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int SP_IDX = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    mode,
  input logic          is_store,
  input logic          two_word,
  input logic [RW-1:0] base_idx,
  input logic [RW-1:0] dest_idx,
  input logic [AW-1:0] base_val,
  input logic [AW-1:0] mod_start,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] new_base,
  input logic          illegal,
  input logic          wb_en,
  input logic [RW-1:0] wb_idx,
  input logic [AW-1:0] wb_data,
  input logic          wrap_hit
);
  AST_POST_ADDR_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode[1] == 1'b0) |-> eff_addr == base_val); // R1
  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |-> new_base == mod_start); // R2
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b10 && !illegal) |-> new_base == eff_addr); // R5
  AST_PREDEC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> !wrap_hit); // R5
  AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !wb_en); // R6
  AST_LOAD_DEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_store && base_idx == dest_idx) |=> !wb_en); // R7
  AST_WB_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !illegal) |=> (!wb_en || (wb_idx == $past(base_idx) &&
                                 wb_data == $past(new_base)))); // R8
  AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !wb_en); // R9
  AST_TWO_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b00 && two_word && !wrap_hit) |->
      new_base == base_val + AW'(4)); // R1
  AST_SP_IDX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == 2'b10 && base_idx == RW'(SP_IDX)) |-> !illegal); // R6
endmodule

bind amg_modulo_agu amg_modulo_agu_chk #(.AW(AW), .RW(RW), .SP_IDX(SP_IDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .mode      (mode),
  .is_store  (is_store),
  .two_word  (two_word),
  .base_idx  (base_idx),
  .dest_idx  (dest_idx),
  .base_val  (base_val),
  .mod_start (mod_start),
  .eff_addr  (eff_addr),
  .new_base  (new_base),
  .illegal   (illegal),
  .wb_en     (wb_en),
  .wb_idx    (wb_idx),
  .wb_data   (wb_data),
  .wrap_hit  (wrap_hit)
);

// File: tb/amg_modulo_agu_bench.sv
`timescale 1ns/1ps
module amg_modulo_agu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        is_store = 1'b0;
  logic        two_word = 1'b0;
  logic [3:0]  base_idx = 4'd1;
  logic [3:0]  dest_idx = 4'd2;
  logic [15:0] base_val = 16'h0;
  logic [15:0] mod_start = 16'h0;
  logic [15:0] mod_end = 16'h0;
  logic        modulo_en = 1'b0;
  logic [15:0] eff_addr, new_base, wb_data;
  logic        illegal, wb_en;
  logic [3:0]  wb_idx;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] cur_base;
  bit done = 0;

  always #10 clk = ~clk;

  amg_modulo_agu u_amg_modulo_agu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .is_store(is_store), .two_word(two_word), .base_idx(base_idx),
    .dest_idx(dest_idx), .base_val(base_val), .mod_start(mod_start),
    .mod_end(mod_end), .modulo_en(modulo_en), .eff_addr(eff_addr),
    .new_base(new_base), .illegal(illegal), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: expected updated base, written from the requirements.
  function automatic logic [15:0] ref_next(input logic [1:0] m, input logic tw,
      input logic me, input logic [15:0] b, input logic [15:0] s, input logic [15:0] e);
    int st;
    logic [15:0] lim;
    st  = tw ? 4 : 2;
    lim = e & (tw ? 16'hFFFC : 16'hFFFE);
    if (m == 2'b10) return b - 16'(st);
    if (m == 2'b11) return b;
    if (me && b == lim) return s;
    return (m == 2'b00) ? b + 16'(st) : b - 16'(st);
  endfunction

  // Drive one request, check comb outputs, then the registered writeback.
  task automatic apply(input logic [1:0] m, input logic st, input logic tw,
      input logic [3:0] bi, input logic [3:0] di, input logic [15:0] b,
      input logic me, input logic [15:0] s, input logic [15:0] e,
      input logic exp_ill, input logic exp_wb, input string tag);
    logic [15:0] exp_nb, exp_ea;
    @(negedge clk);
    req_valid = 1'b1; mode = m; is_store = st; two_word = tw;
    base_idx = bi; dest_idx = di; base_val = b; modulo_en = me;
    mod_start = s; mod_end = e;
    exp_nb = ref_next(m, tw, me, b, s, e);
    exp_ea = (m == 2'b10) ? exp_nb : b;
    #1;
    check(illegal == exp_ill, {tag, " illegal"}, 16'(illegal), 16'(exp_ill));
    if (!exp_ill) begin
      check(eff_addr == exp_ea, {tag, " eff_addr"}, eff_addr, exp_ea);
      check(new_base == exp_nb, {tag, " new_base"}, new_base, exp_nb);
    end
    @(negedge clk);
    req_valid = 1'b0;
    check(wb_en == exp_wb, {tag, " wb_en"}, 16'(wb_en), 16'(exp_wb));
    if (exp_wb) begin
      check(wb_idx == bi, {tag, " wb_idx R8"}, 16'(wb_idx), 16'(bi));
      check(wb_data == exp_nb, {tag, " wb_data R8"}, wb_data, exp_nb);
    end
    cur_base = new_base;
  endtask

  // One step of a pointer walk; expected value given literally.
  task automatic walk(input logic [1:0] m, input logic tw, input logic me,
      input logic [15:0] s, input logic [15:0] e, input logic [15:0] exp_next,
      input string tag);
    logic [15:0] b;
    b = cur_base;
    apply(m, 1'b0, tw, 4'd1, 4'd4, b, me, s, e, 1'b0, 1'b1, tag);
    check(cur_base == exp_next, {tag, " walk"}, cur_base, exp_next);
    cur_base = exp_next;
  endtask

  task automatic t_reset();
    #1;
    check(wb_en == 1'b0, "R8 reset wb_en", 16'(wb_en), 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(wb_en == 1'b0, "R8 after reset wb_en", 16'(wb_en), 16'h0);
  endtask

  task automatic t_inc_wrap();
    cur_base = 16'h0100;
    walk(2'b00, 0, 1, 16'h0100, 16'h0108, 16'h0102, "R1 inc word");
    walk(2'b00, 0, 1, 16'h0100, 16'h0108, 16'h0104, "R1 inc word");
    walk(2'b00, 0, 1, 16'h0100, 16'h0108, 16'h0106, "R1 inc word");
    walk(2'b00, 0, 1, 16'h0100, 16'h0108, 16'h0108, "R1 inc word");
    walk(2'b00, 0, 1, 16'h0100, 16'h0108, 16'h0100, "R2 inc word wrap");
    cur_base = 16'h0100;
    walk(2'b00, 1, 1, 16'h0100, 16'h0108, 16'h0104, "R2 inc dword");
    walk(2'b00, 1, 1, 16'h0100, 16'h0108, 16'h0108, "R2 inc dword");
    walk(2'b00, 1, 1, 16'h0100, 16'h0108, 16'h0100, "R2 inc dword wrap");
  endtask

  task automatic t_odd_end();
    cur_base = 16'h0104;
    walk(2'b00, 0, 1, 16'h0100, 16'h0107, 16'h0106, "R2 odd end");
    walk(2'b00, 0, 1, 16'h0100, 16'h0107, 16'h0100, "R2 odd end wrap");
    cur_base = 16'h0104;
    walk(2'b00, 1, 1, 16'h0100, 16'h0107, 16'h0100, "R2 odd end dword wrap");
  endtask

  task automatic t_dec_wrap();
    cur_base = 16'h0108;
    walk(2'b01, 0, 1, 16'h0108, 16'h0100, 16'h0106, "R3 dec word");
    walk(2'b01, 0, 1, 16'h0108, 16'h0100, 16'h0104, "R3 dec word");
    walk(2'b01, 0, 1, 16'h0108, 16'h0100, 16'h0102, "R3 dec word");
    walk(2'b01, 0, 1, 16'h0108, 16'h0100, 16'h0100, "R3 dec word");
    walk(2'b01, 0, 1, 16'h0108, 16'h0100, 16'h0108, "R3 dec word wrap");
    cur_base = 16'h0108;
    walk(2'b01, 1, 1, 16'h0108, 16'h0100, 16'h0104, "R3 dec dword");
    walk(2'b01, 1, 1, 16'h0108, 16'h0100, 16'h0100, "R3 dec dword");
    walk(2'b01, 1, 1, 16'h0108, 16'h0100, 16'h0108, "R3 dec dword wrap");
  endtask

  task automatic t_no_modulo();
    cur_base = 16'h0102;
    walk(2'b01, 0, 0, 16'h0108, 16'h0100, 16'h0100, "R4 dec plain");
    walk(2'b01, 0, 0, 16'h0108, 16'h0100, 16'h00FE, "R4 dec plain");
    walk(2'b01, 0, 0, 16'h0108, 16'h0100, 16'h00FC, "R4 dec plain");
    cur_base = 16'h0108;
    walk(2'b00, 1, 0, 16'h0100, 16'h0108, 16'h010C, "R4 inc dword plain");
    walk(2'b00, 1, 0, 16'h0100, 16'h0108, 16'h0110, "R4 inc dword plain");
    cur_base = 16'hFFFE;
    walk(2'b00, 0, 0, 16'h0100, 16'h0108, 16'h0000, "R1 16-bit rollover");
  endtask

  task automatic t_predec();
    apply(2'b10, 1, 1, 4'd15, 4'd0, 16'h4004, 0, 16'h0, 16'h0, 0, 1, "R5 predec dword");
    check(eff_addr == 16'h4000 && cur_base == 16'h4000, "R5 predec value", cur_base, 16'h4000);
    apply(2'b10, 1, 0, 4'd15, 4'd0, 16'h4004, 1, 16'h0100, 16'h4004, 0, 1, "R5 predec no wrap");
    check(cur_base == 16'h4002, "R5 predec ignores bounds", cur_base, 16'h4002);
  endtask

  task automatic t_illegal();
    apply(2'b01, 1, 0, 4'd15, 4'd0, 16'h2000, 0, 16'h0, 16'h0, 1, 0, "R6 st postdec sp");
    apply(2'b01, 1, 1, 4'd15, 4'd0, 16'h2000, 0, 16'h0, 16'h0, 1, 0, "R6 st2 postdec sp");
    apply(2'b10, 1, 0, 4'd3, 4'd0, 16'h2000, 0, 16'h0, 16'h0, 1, 0, "R6 predec non-sp");
    apply(2'b11, 0, 0, 4'd3, 4'd0, 16'h2000, 0, 16'h0, 16'h0, 1, 0, "R6 reserved mode");
    apply(2'b01, 0, 0, 4'd15, 4'd0, 16'h2000, 0, 16'h0, 16'h0, 0, 1, "R6 ld postdec sp legal");
  endtask

  task automatic t_suppress();
    apply(2'b00, 0, 0, 4'd5, 4'd5, 16'h0300, 0, 16'h0, 16'h0, 0, 0, "R7 ld base=dest");
    apply(2'b00, 0, 1, 4'd6, 4'd5, 16'h0300, 0, 16'h0, 16'h0, 0, 0, "R7 ld2 base=dest+1");
    apply(2'b00, 0, 0, 4'd6, 4'd5, 16'h0300, 0, 16'h0, 16'h0, 0, 1, "R7 ld1 base=dest+1");
    apply(2'b00, 1, 0, 4'd5, 4'd5, 16'h0300, 0, 16'h0, 16'h0, 0, 1, "R7 st base=src");
    apply(2'b01, 0, 1, 4'd0, 4'd15, 16'h0300, 0, 16'h0, 16'h0, 0, 0, "R7 ld2 index wrap");
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0; mode = 2'b00; is_store = 1'b1; base_idx = 4'd2;
    base_val = 16'h0500;
    @(negedge clk);
    check(wb_en == 1'b0, "R9 idle wb_en", 16'(wb_en), 16'h0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_inc_wrap();
    t_odd_end();
    t_dec_wrap();
    t_no_modulo();
    t_predec();
    t_illegal();
    t_suppress();
    t_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule